// File: doc/BRIEF.md
# Carry-Free Signed-Digit Adder

This block adds two numbers that are each held as N radix-4 signed digits. Every digit lies in the symmetric range -3 to +3 and is stored as a 3-bit two's-complement field. Digit 0 sits in bits [2:0], and digit i sits in bits [3i+2:3i]. The result uses the same digit format and has one extra digit at the top. Because the digit set is redundant, each result digit is formed from the operand digits at its own position and at the position just below it. No carry chain runs along the word, so the adder delay stays the same for any N.

Both operands are captured on a valid strobe, and the sum appears one clock later. A sign-detect output also reports whether the result is negative or zero. To find this it scans for the most significant nonzero digit, so its delay does grow with N. Converting the result back to ordinary binary is left to the user.

Top module: `sd_adder`

## Requirements
- R1: Every result digit 0..N-1 is a 3-bit two's-complement value in the range -3..+3 (the code 3'b100 never appears), given operand digits in -3..+3.
- R2: The value of the result, sum over i of digit_i·4^i with N+1 digits, equals the value of x plus the value of y.
- R3: `out_valid` is high in exactly the cycle that follows a clock edge at which `in_valid` was high and reset was low.
- R4: When `in_valid` is low at a clock edge, the captured operands do not change, so `sum_dig` holds its previous value.
- R5: A synchronous active-high reset clears the captured operands and `out_valid`. After reset, `sum_dig` is all zero, `sum_zero` is 1 and `sum_neg` is 0.
- R6: At each position i, let t = x_i + y_i. The outgoing transfer is +1 if t ≥ 2, -1 if t ≤ -2, and 0 otherwise. The interim digit is t - 4·transfer and lies in -2..+2. Result digit i equals the interim digit plus the transfer from position i-1, and the transfer into digit 0 is zero.
- R7: Result digit N, in bits [3N+2:3N], equals the transfer out of position N-1 and lies in -1..+1.
- R8: `sum_neg` is 1 exactly when the result value is negative, and `sum_zero` is 1 exactly when the result value is zero. The two flags are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Capture strobe for both operands |
| x_dig | input | 3*N | Operand x, N signed digits |
| y_dig | input | 3*N | Operand y, N signed digits |
| out_valid | output | 1 | Result valid (one cycle after capture) |
| sum_dig | output | 3*N+3 | Result, N+1 signed digits |
| sum_neg | output | 1 | Result value is negative |
| sum_zero | output | 1 | Result value is zero |

## Verification
A two-digit configuration is swept over all 2401 legal operand pairs. For each pair the bench checks the result digit by digit against the transfer rule, which confirms that digit 1 sees only digits 0 and 1. It also checks the integer value of the result, which confirms the addition itself, and checks the sign flags, which confirms the scan. Pairs with digit sums of exactly ±2 and ±6 cover the thresholds where a transfer is selected and where an incoming transfer must be absorbed. A hold phase changes the operand inputs while the strobe is low, and a mid-run reset checks that the clear state is restored.

// File: rtl/sd_adder.sv
module sd_adder #(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [3*N-1:0] x_dig,
  input  logic [3*N-1:0] y_dig,
  output logic           out_valid,
  output logic [3*N+2:0] sum_dig,
  output logic           sum_neg,
  output logic           sum_zero
);
  localparam int W = 3 * N;

  logic [W-1:0] xq, yq;
  logic signed [1:0] xfer [0:N];

  always_ff @(posedge clk) begin
    if (rst) begin
      xq <= '0;
      yq <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        xq <= x_dig;
        yq <= y_dig;
      end
    end
  end

  assign xfer[0] = 2'sd0;

  for (genvar gi = 0; gi < N; gi++) begin : g_dig
    logic [2:0] xd, yd;
    logic signed [3:0] t, cout4, cin4, w4, s4;
    assign xd = xq[3*gi +: 3];
    assign yd = yq[3*gi +: 3];
    assign t = $signed({xd[2], xd}) + $signed({yd[2], yd});
    assign xfer[gi+1] = (t >= 4'sd2) ? 2'sd1 : (t <= -4'sd2) ? -2'sd1 : 2'sd0;
    assign cout4 = {{2{xfer[gi+1][1]}}, xfer[gi+1]};
    assign cin4  = {{2{xfer[gi][1]}}, xfer[gi]};
    assign w4 = t - (cout4 <<< 2);
    assign s4 = w4 + cin4;
    assign sum_dig[3*gi +: 3] = s4[2:0];

    p_interim_r6: assert property (@(posedge clk) disable iff (rst)
      (w4 >= -4'sd2) && (w4 <= 4'sd2));
    p_digit_range_r1: assert property (@(posedge clk) disable iff (rst)
      (sum_dig[3*gi +: 3] != 3'b100) && (s4 >= -4'sd3) && (s4 <= 4'sd3));
  end

  assign sum_dig[W +: 3] = {xfer[N][1], xfer[N]};

  always_comb begin
    sum_neg  = 1'b0;
    sum_zero = 1'b1;
    for (int i = N; i >= 0; i--) begin
      if (sum_zero && sum_dig[3*i +: 3] != 3'b000) begin
        sum_neg  = sum_dig[3*i+2];
        sum_zero = 1'b0;
      end
    end
  end

  p_top_range_r7: assert property (@(posedge clk) disable iff (rst)
    sum_dig[W+2] == sum_dig[W+1]);
  p_valid_lat_r3: assert property (@(posedge clk) disable iff (rst)
    ($past(in_valid) && !$past(rst)) |-> out_valid);
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(in_valid) && !$past(rst)) |-> ($stable(sum_dig) && !out_valid));
  p_reset_r5: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && sum_dig == '0));
  p_flags_r8: assert property (@(posedge clk) disable iff (rst)
    !(sum_neg && sum_zero) && (sum_zero == (sum_dig == '0)));
endmodule

// File: tb/sim_sd_adder.sv
module sim_sd_adder;
  localparam int N = 2;
  localparam int W = 3 * N;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [W-1:0] x_dig = '0, y_dig = '0;
  logic out_valid, sum_neg, sum_zero;
  logic [W+2:0] sum_dig;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  sd_adder #(.N(N)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .x_dig(x_dig), .y_dig(y_dig),
    .out_valid(out_valid), .sum_dig(sum_dig), .sum_neg(sum_neg), .sum_zero(sum_zero)
  );

  function automatic int dval(input logic [2:0] d);
    return d[2] ? int'(d) - 8 : int'(d);
  endfunction

  function automatic int value(input logic [W+2:0] v);
    int acc = 0;
    for (int i = N; i >= 0; i--) acc = acc * 4 + dval(v[3*i +: 3]);
    return acc;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_reset_state();
    check(out_valid == 1'b0, "R5 out_valid", int'(out_valid), 0);
    check(sum_dig == '0, "R5 sum_dig", int'(sum_dig), 0);
    check(sum_zero == 1'b1 && sum_neg == 1'b0, "R5 flags",
          int'({sum_neg, sum_zero}), 1);
  endtask

  initial begin
    logic [W+2:0] held;
    #200000;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [W+2:0] held;
    int xv, yv, exp_v;
    int t [0:N-1];
    int c [0:N];
    int ed;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_reset_state();

    for (int a1 = -3; a1 <= 3; a1++)
      for (int a0 = -3; a0 <= 3; a0++)
        for (int b1 = -3; b1 <= 3; b1++)
          for (int b0 = -3; b0 <= 3; b0++) begin
            x_dig = {3'(a1), 3'(a0)};
            y_dig = {3'(b1), 3'(b0)};
            in_valid = 1'b1;
            @(negedge clk);
            xv = a1 * 4 + a0;
            yv = b1 * 4 + b0;
            exp_v = xv + yv;
            t[0] = a0 + b0;
            t[1] = a1 + b1;
            c[0] = 0;
            for (int i = 0; i < N; i++)
              c[i+1] = (t[i] >= 2) ? 1 : (t[i] <= -2) ? -1 : 0;
            check(out_valid == 1'b1, "R3 out_valid", int'(out_valid), 1);
            check(value(sum_dig) == exp_v, "R2 value", value(sum_dig), exp_v);
            for (int i = 0; i < N; i++) begin
              ed = t[i] - 4 * c[i+1] + c[i];
              check(sum_dig[3*i +: 3] != 3'b100 && dval(sum_dig[3*i +: 3]) >= -3 &&
                    dval(sum_dig[3*i +: 3]) <= 3, "R1 digit range",
                    dval(sum_dig[3*i +: 3]), ed);
              check(dval(sum_dig[3*i +: 3]) == ed, "R6 digit", dval(sum_dig[3*i +: 3]), ed);
            end
            check(dval(sum_dig[W +: 3]) == c[N], "R7 top digit",
                  dval(sum_dig[W +: 3]), c[N]);
            check(sum_neg == (exp_v < 0), "R8 neg", int'(sum_neg), int'(exp_v < 0));
            check(sum_zero == (exp_v == 0), "R8 zero", int'(sum_zero), int'(exp_v == 0));
          end

    x_dig = {3'(3), 3'(3)};
    y_dig = {3'(3), 3'(3)};
    @(negedge clk);
    in_valid = 1'b0;
    held = sum_dig;
    check(value(sum_dig) == 30, "R2 max value", value(sum_dig), 30);
    x_dig = {3'(-3), 3'(1)};
    y_dig = {3'(-2), 3'(-1)};
    repeat (2) @(negedge clk);
    check(sum_dig == held, "R4 hold", value(sum_dig), value(held));
    check(out_valid == 1'b0, "R3 no strobe", int'(out_valid), 0);

    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_reset_state();

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule